// File: doc/BRIEF.md
# Independent Windowed Watchdog

This block supervises software from a slow clock of its own (nominally about 40 kHz), separate from the system clock. It therefore keeps counting while the rest of the chip sits in a stop or standby low-power state. A prescaler divides the slow clock by a selectable power of two. Each prescaler tick decrements a 12-bit down-counter. Software must refresh the counter by writing a key, and must do so only after the counter has dropped to or below a programmable window value. A refresh that comes too early, or no refresh before the count runs out, produces a one-cycle fault pulse in the system clock domain.

Software reaches the block through a single write stream in the system domain. Each write carries a 2-bit register selector and 16 data bits and is accepted on valid and ready together. Every accepted write crosses into the slow domain through a toggle handshake. Ready stays low until the slow side has applied the write, so a second write is held back until then. The producer must keep `wr_addr` and `wr_data` stable while `wr_valid` is high and ready is low. The watchdog starts in one of two ways:
- from reset, when a non-volatile strap is set;
- by a start key otherwise.

Once running, the watchdog can only be stopped by a reset. A strap also turns the fault into a periodic timeout event instead of a reset request. A debug input freezes the count.

Top module: `wdg_top`

## Requirements
- R1: After reset with `hw_start` low, the block is idle. No `rst_req` or `timeout_evt` pulse appears however long the clocks run, and `wr_ready` is high.
- R2: The prescaler divides the slow clock by 4 × 2^code, limited to 256, so code 6 and code 7 both give 256. A start or refresh clears the prescaler and loads the counter with the reload value R. The fault then follows after max(R,1) × divider slow-clock cycles if nothing intervenes.
- R3: The registers are selected by `wr_addr`:
  - 0 = key register. 16'h3C5A starts, 16'hA5C3 refreshes, 16'h6E91 unlocks.
  - 1 = prescaler code, data bits [2:0].
  - 2 = reload value, bits [11:0].
  - 3 = window value, bits [11:0].
  
  Reset values are code 0, reload 12'hFFF and window 12'hFFF.
- R4: Writes to addresses 1 to 3 are ignored unless the unlock key was written after the last refresh key. A refresh key locks the registers again.
- R5: A refresh key while the watchdog runs and the counter is above the window value is a fault.
- R6: A refresh key while the counter is at or below the window value reloads the counter without a fault.
- R7: With `hw_start` high the watchdog counts from reset, with no start key needed.
- R8: Once started, no write stops the watchdog. A start key while running has no effect.
- R9: While `dbg_freeze` is high the prescaler and counter hold. Counting resumes when it is released.
- R10: With `timer_only` high every fault appears on `timeout_evt` and never on `rst_req`. The counter reloads after each expiry, so timeouts repeat every R × divider slow cycles.
- R11: A write is accepted when `wr_valid` and `wr_ready` are both high. `wr_ready` is low in the cycle after acceptance and returns high once the write has been applied in the slow domain.
- R12: Each fault gives exactly one pulse, one system cycle wide, on `rst_req` (or on `timeout_evt` in timer mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the write stream and fault outputs |
| wd_clk | input | 1 | Independent slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised into each domain |
| hw_start | input | 1 | Non-volatile strap: watchdog runs from reset |
| timer_only | input | 1 | Strap: route faults to `timeout_evt` instead of `rst_req` |
| dbg_freeze | input | 1 | Debug halt; counting pauses while high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request may be accepted |
| wr_addr | input | 2 | Register selector (R3) |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-cycle reset request pulse, system domain |
| timeout_evt | output | 1 | One-cycle timeout pulse in timer mode, system domain |

## Verification
The assertions assume the following about the inputs:
- `hw_start` and `timer_only` change only while reset is held.
- `wr_addr` and `wr_data` stay stable while a write waits for ready.
- The two clocks are free-running and unrelated.

The stimulus applies the straps only inside the reset task and drives each write from negative clock edges, holding it until ready is seen. The slow clock runs at a non-integer ratio to the system clock, so crossing latencies vary. Timing checks therefore allow a bounded tolerance around the ideal slow-cycle count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned DATA_W = 16;

  localparam logic [DATA_W-1:0] KEY_START = 16'h3C5A;
  localparam logic [DATA_W-1:0] KEY_FEED  = 16'hA5C3;
  localparam logic [DATA_W-1:0] KEY_OPEN  = 16'h6E91;

  typedef enum logic [1:0] {
    REG_KEY    = 2'd0,
    REG_DIV    = 2'd1,
    REG_RELOAD = 2'd2,
    REG_WINDOW = 2'd3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e            sel;
    logic [DATA_W-1:0]   data;
  } wr_pkt_t;

endpackage

// File: rtl/wdg_sync.sv
// Multi-stage synchroniser. With d tied high it is used as a reset
// synchroniser: assertion is asynchronous, release is synchronous.
module wdg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wdg_wr_cdc.sv
// Carries one register write at a time from the system domain into the
// slow domain with a toggle request and a toggle acknowledge.
module wdg_wr_cdc
  import wdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    src_clk,
  input  logic    src_rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  wr_pkt_t in_pkt,
  input  logic    dst_clk,
  input  logic    dst_rst_n,
  output logic    out_fire,
  output wr_pkt_t out_pkt
);

  logic    req_tgl;
  logic    ack_src;
  logic    req_dst;
  logic    req_dst_q;
  wr_pkt_t hold;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_tgl <= 1'b0;
      hold    <= '0;
    end else if (in_valid && in_ready) begin
      req_tgl <= ~req_tgl;
      hold    <= in_pkt;
    end
  end

  assign in_ready = (req_tgl == ack_src);

  wdg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (req_tgl),
    .q     (req_dst)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) req_dst_q <= 1'b0;
    else            req_dst_q <= req_dst;
  end

  // hold has been stable for at least SYNC_STAGES slow cycles here
  assign out_fire = req_dst ^ req_dst_q;
  assign out_pkt  = hold;

  wdg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (req_dst_q),
    .q     (ack_src)
  );

endmodule

// File: rtl/wdg_core.sv
// Slow-domain watchdog: register file, lock, prescaler, down-counter and
// window comparison. Every fault toggles fault_tgl once.
module wdg_core
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MIN_LOG2 = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hw_start,
  input  logic    frz,
  input  logic    wr_fire,
  input  wr_pkt_t wr_pkt,
  output logic    fault_tgl
);

  localparam int unsigned     MAX_LOG2 = PRE_W;
  localparam logic [CNT_W-1:0] CNT_INIT = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CODE_W-1:0] div_code;
  logic [CNT_W-1:0]  reload_v;
  logic [CNT_W-1:0]  window_v;
  logic [CNT_W-1:0]  cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  pre_last;
  logic              open_q;
  logic              started;
  logic              active;
  logic              run_step;
  logic              tick;
  logic              is_key;
  logic              key_start;
  logic              key_feed;
  logic              key_open;
  logic              cfg_ok;
  logic              restart;
  logic              early;
  logic              expire;
  logic              unused_data_bits;

  function automatic logic [PRE_W-1:0] last_of(input logic [CODE_W-1:0] code);
    int unsigned sh;
    sh = MIN_LOG2 + 32'(code);
    if (sh > MAX_LOG2) sh = MAX_LOG2;
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction

  assign pre_last  = last_of(div_code);
  assign unused_data_bits = ^wr_pkt.data;

  assign is_key    = wr_fire && (wr_pkt.sel == REG_KEY);
  assign key_start = is_key && (wr_pkt.data == KEY_START);
  assign key_feed  = is_key && (wr_pkt.data == KEY_FEED);
  assign key_open  = is_key && (wr_pkt.data == KEY_OPEN);
  assign cfg_ok    = wr_fire && open_q && (wr_pkt.sel != REG_KEY);

  assign active    = started || hw_start;
  assign restart   = key_feed || (key_start && !active);
  assign run_step  = active && !frz;
  assign tick      = run_step && (pre_cnt >= pre_last);
  assign early     = key_feed && active && (cnt > window_v);
  assign expire    = tick && !restart && (cnt <= CNT_ONE);

  // configuration, lock and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_code <= '0;
      reload_v <= CNT_INIT;
      window_v <= CNT_INIT;
      open_q   <= 1'b0;
      started  <= 1'b0;
    end else begin
      if (key_start) started <= 1'b1;
      if (key_open)      open_q <= 1'b1;
      else if (key_feed) open_q <= 1'b0;
      if (cfg_ok) begin
        case (wr_pkt.sel)
          REG_DIV:    div_code <= wr_pkt.data[CODE_W-1:0];
          REG_RELOAD: reload_v <= wr_pkt.data[CNT_W-1:0];
          REG_WINDOW: window_v <= wr_pkt.data[CNT_W-1:0];
          default:    ;
        endcase
      end
    end
  end

  // prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_cnt <= '0;
    else if (restart)           pre_cnt <= '0;
    else if (run_step) begin
      if (pre_cnt >= pre_last)  pre_cnt <= '0;
      else                      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CNT_INIT;
    else if (restart)     cnt <= reload_v;
    else if (tick) begin
      if (cnt <= CNT_ONE) cnt <= reload_v;
      else                cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               fault_tgl <= 1'b0;
    else if (early || expire) fault_tgl <= ~fault_tgl;
  end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        sys_clk,
  input  logic        wd_clk,
  input  logic        rst_n,
  input  logic        hw_start,
  input  logic        timer_only,
  input  logic        dbg_freeze,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        rst_req,
  output logic        timeout_evt
);

  logic    sys_rst_n;
  logic    wd_rst_n;
  logic    frz_wd;
  logic    wr_fire;
  logic    fault_tgl;
  logic    fault_sys;
  logic    fault_sys_q;
  logic    evt_q;
  wr_pkt_t in_pkt;
  wr_pkt_t wd_pkt;

  wdg_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(sys_clk), .rst_n(rst_n), .d(1'b1), .q(sys_rst_n)
  );

  wdg_sync #(.STAGES(SYNC_STAGES)) u_wd_rst (
    .clk(wd_clk), .rst_n(rst_n), .d(1'b1), .q(wd_rst_n)
  );

  wdg_sync #(.STAGES(SYNC_STAGES)) u_frz_sync (
    .clk(wd_clk), .rst_n(wd_rst_n), .d(dbg_freeze), .q(frz_wd)
  );

  assign in_pkt.sel  = reg_sel_e'(wr_addr);
  assign in_pkt.data = wr_data;

  wdg_wr_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_wr (
    .src_clk   (sys_clk),
    .src_rst_n (sys_rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_pkt    (in_pkt),
    .dst_clk   (wd_clk),
    .dst_rst_n (wd_rst_n),
    .out_fire  (wr_fire),
    .out_pkt   (wd_pkt)
  );

  wdg_core #(
    .CNT_W  (CNT_W),
    .PRE_W  (PRE_W),
    .CODE_W (CODE_W)
  ) u_core (
    .clk       (wd_clk),
    .rst_n     (wd_rst_n),
    .hw_start  (hw_start),
    .frz       (frz_wd),
    .wr_fire   (wr_fire),
    .wr_pkt    (wd_pkt),
    .fault_tgl (fault_tgl)
  );

  // fault toggle back into the system domain as a one-cycle pulse
  wdg_sync #(.STAGES(SYNC_STAGES)) u_fault_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(fault_tgl), .q(fault_sys)
  );

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      fault_sys_q <= 1'b0;
      evt_q       <= 1'b0;
    end else begin
      fault_sys_q <= fault_sys;
      evt_q       <= fault_sys ^ fault_sys_q;
    end
  end

  assign rst_req     = evt_q && !timer_only;
  assign timeout_evt = evt_q && timer_only;

endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned CODE_W = 3
) (
  input logic              sys_clk,
  input logic              wd_clk,
  input logic              sys_rst_n,
  input logic              wd_rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rst_req,
  input logic              timeout_evt,
  input logic              active,
  input logic              frz,
  input logic              wr_fire,
  input logic              is_key,
  input logic              open_q,
  input logic              key_feed,
  input logic              fault_tgl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  window_v,
  input logic [CNT_W-1:0]  reload_v,
  input logic [CODE_W-1:0] div_code
);

  AST_RST_PULSE_ONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    rst_req |=> !rst_req); // R12

  AST_TMO_PULSE_ONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    timeout_evt |=> !timeout_evt); // R12

  AST_READY_CLOSES: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_valid && wr_ready) |=> !wr_ready); // R11

  AST_NEVER_STOPS: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    active |=> active); // R8

  AST_FREEZE_HOLDS: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (frz && !wr_fire) |=> $stable(cnt)); // R9

  AST_EARLY_FAULTS: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (key_feed && active && (cnt > window_v)) |=> (fault_tgl != $past(fault_tgl))); // R5

  AST_LOCKED_CFG: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (wr_fire && !is_key && !open_q) |=>
      ($stable(reload_v) && $stable(window_v) && $stable(div_code))); // R4

endmodule

bind wdg_top wdg_top_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .sys_clk     (sys_clk),
  .wd_clk      (wd_clk),
  .sys_rst_n   (sys_rst_n),
  .wd_rst_n    (wd_rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rst_req     (rst_req),
  .timeout_evt (timeout_evt),
  .active      (u_core.active),
  .frz         (frz_wd),
  .wr_fire     (wr_fire),
  .is_key      (u_core.is_key),
  .open_q      (u_core.open_q),
  .key_feed    (u_core.key_feed),
  .fault_tgl   (fault_tgl),
  .cnt         (u_core.cnt),
  .window_v    (u_core.window_v),
  .reload_v    (u_core.reload_v),
  .div_code    (u_core.div_code)
);

// File: tb/wdg_top_tb.sv
`timescale 1ns/100ps
module wdg_top_tb;

  localparam logic [15:0] K_START = 16'h3C5A;
  localparam logic [15:0] K_FEED  = 16'hA5C3;
  localparam logic [15:0] K_OPEN  = 16'h6E91;
  localparam int LAT = 25;   // crossing latency in system cycles
  localparam int TOL = 16;

  // {code, reload, expected slow cycles to fault}
  localparam logic [34:0] VEC [8] = '{
    {3'd0, 12'd20, 20'd80},
    {3'd1, 12'd15, 20'd120},
    {3'd2, 12'd8,  20'd128},
    {3'd5, 12'd3,  20'd384},
    {3'd7, 12'd2,  20'd512},
    {3'd6, 12'd2,  20'd512},
    {3'd0, 12'd1,  20'd4},
    {3'd3, 12'd0,  20'd32}
  };

  logic        sys_clk = 1'b0;
  logic        wd_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_start = 1'b0;
  logic        timer_only = 1'b0;
  logic        dbg_freeze = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        rst_req;
  logic        timeout_evt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t_ref = 0;

  always #5 sys_clk = ~sys_clk;
  always #36.5 wd_clk = ~wd_clk;
  always @(posedge sys_clk) cyc <= cyc + 1;

  wdg_top u_dut (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .rst_n(rst_n), .hw_start(hw_start),
    .timer_only(timer_only), .dbg_freeze(dbg_freeze), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_req(rst_req), .timeout_evt(timeout_evt)
  );

  function automatic int to_sys(input int wd);
    return (wd * 73) / 10;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit hw, input bit tonly);
    @(negedge sys_clk);
    rst_n = 1'b0; hw_start = hw; timer_only = tonly; dbg_freeze = 1'b0; wr_valid = 1'b0;
    repeat (20) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (20) @(negedge sys_clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge sys_clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge sys_clk);
    t_ref = cyc + 1;
    @(negedge sys_clk);
    wr_valid = 1'b0;
  endtask

  // waits for the wanted pulse; dt relative to t_ref, -1 if none
  task automatic wait_evt(input bit want_tmo, input int max_cyc, output int dt, output int other);
    dt = -1; other = 0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge sys_clk);
      if (want_tmo ? rst_req : timeout_evt) other++;
      if (want_tmo ? timeout_evt : rst_req) begin
        dt = cyc - t_ref;
        break;
      end
    end
  endtask

  function automatic bit near(input int act, input int exp);
    return (act >= exp - TOL) && (act <= exp + TOL);
  endfunction

  initial begin
    #(2_000_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dt;
    int oth;
    int exp;
    int n;

    // vector table: divider and reload timing
    for (int v = 0; v < 8; v++) begin
      do_reset(1'b0, 1'b0);
      wr(2'd0, K_OPEN);
      wr(2'd1, {13'd0, VEC[v][34:32]});
      wr(2'd2, {4'd0, VEC[v][31:20]});
      wr(2'd0, K_START);
      exp = to_sys(int'(VEC[v][19:0])) + LAT;
      wait_evt(1'b0, exp + 200, dt, oth);
      chk(near(dt, exp), "R2 R3", dt, exp);
    end

    // R1: idle after reset
    do_reset(1'b0, 1'b0);
    chk(wr_ready == 1'b1, "R1", int'(wr_ready), 1);
    wait_evt(1'b0, 3000, dt, oth);
    chk(dt == -1 && oth == 0, "R1", dt, -1);

    // R11: back-pressure on the write stream
    @(negedge sys_clk);
    wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000;
    while (!wr_ready) @(negedge sys_clk);
    @(negedge sys_clk);
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R11", int'(wr_ready), 0);
    n = 0;
    while (!wr_ready && n < 200) begin @(negedge sys_clk); n++; end
    chk(n >= 2 && n <= 60, "R11", n, 30);

    // R4: lock after refresh ignores a new reload value
    do_reset(1'b0, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd30);
    wr(2'd0, K_FEED);
    wr(2'd2, 16'd2);
    wr(2'd0, K_START);
    exp = to_sys(120) + LAT;
    wait_evt(1'b0, exp + 200, dt, oth);
    chk(near(dt, exp), "R4", dt, exp);

    // R5: refresh above the window faults at once; R12 single pulse
    do_reset(1'b0, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd40);
    wr(2'd3, 16'd20);
    wr(2'd0, K_START);
    wait_evt(1'b0, 150, dt, oth);
    chk(dt == -1, "R5", dt, -1);
    wr(2'd0, K_FEED);
    wait_evt(1'b0, 200, dt, oth);
    chk(dt >= 0 && dt <= 60, "R5", dt, LAT);
    @(negedge sys_clk);
    chk(rst_req == 1'b0, "R12", int'(rst_req), 0);

    // R6: refresh inside the window reloads without fault
    do_reset(1'b0, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd40);
    wr(2'd3, 16'd20);
    wr(2'd0, K_START);
    wait_evt(1'b0, 800, dt, oth);
    chk(dt == -1, "R6", dt, -1);
    wr(2'd0, K_FEED);
    exp = to_sys(160) + LAT;
    wait_evt(1'b0, exp + 200, dt, oth);
    chk(near(dt, exp), "R6", dt, exp);

    // R7: hardware start runs without a start key
    do_reset(1'b1, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd10);
    wr(2'd0, K_FEED);
    exp = to_sys(40) + LAT;
    wait_evt(1'b0, exp + 200, dt, oth);
    chk(near(dt, exp), "R7", dt, exp);
    do_reset(1'b0, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd10);
    wr(2'd0, K_FEED);
    wait_evt(1'b0, 2000, dt, oth);
    chk(dt == -1, "R7", dt, -1);

    // R8: stray keys and a second start do not stop or restart it
    do_reset(1'b0, 1'b0);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd50);
    wr(2'd0, K_START);
    n = t_ref;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, K_START);
    wr(2'd0, K_OPEN);
    t_ref = n;
    exp = to_sys(200) + LAT;
    wait_evt(1'b0, exp + 200, dt, oth);
    chk(near(dt, exp), "R8", dt, exp);

    // R9: debug freeze holds the count
    do_reset(1'b0, 1'b0);
    dbg_freeze = 1'b1;
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd10);
    wr(2'd0, K_START);
    wait_evt(1'b0, 2000, dt, oth);
    chk(dt == -1, "R9", dt, -1);
    @(negedge sys_clk);
    dbg_freeze = 1'b0;
    t_ref = cyc;
    exp = to_sys(40) + LAT;
    wait_evt(1'b0, exp + 200, dt, oth);
    chk(near(dt, exp), "R9", dt, exp);

    // R10: timer mode, periodic timeouts, no reset request
    do_reset(1'b0, 1'b1);
    wr(2'd0, K_OPEN);
    wr(2'd2, 16'd10);
    wr(2'd0, K_START);
    exp = to_sys(40) + LAT;
    wait_evt(1'b1, exp + 200, dt, oth);
    chk(near(dt, exp) && oth == 0, "R10", dt, exp);
    t_ref = cyc;
    exp = to_sys(40);
    wait_evt(1'b1, exp + 200, dt, oth);
    chk(near(dt, exp) && oth == 0, "R10", dt, exp);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule